// File: doc/BRIEF.md
# Power Mode and Reset Controller

This controller sits beside the core of a small 8-bit microcontroller and owns its reset and its two low-power states. The raw active-high reset pin is brought into the clock domain through two flip-flops. A reset is recognised only after the synchronised level has been seen high on two full machine cycles' worth of consecutive clocks, at 12 clocks per machine cycle. While the reset is recognised the block asserts a synchronous core reset. It also forces the ports high and presents the stack-pointer reset value. The serial data buffer is the one register that must not be cleared, so its clear strobe is never raised.

Software requests the low-power states by writing the power-control bits. Bit 0 requests idle: the core clock enable drops, the oscillator keeps running, and a pending interrupt or a reset returns the core to run with a one-cycle wake pulse. Bit 1 requests power-down: both the core clock enable and the oscillator enable drop, and only a reset ends the state. The clock that feeds this block is taken to be a free-running reference, so reset sampling continues while the oscillator is off.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: The reset pin passes through two flip-flops. A reset is recognised only when the synchronised level has been high on 24 consecutive clocks. Any single low sample restarts the count, so a pin held high for 23 clocks, or broken by one low clock, never raises `core_rst`.
- R2: When the pin rises just before a clock edge, `core_rst` is first high after the 26th edge. It stays high while the pin stays high, and it falls after the 3rd edge following the pin going low. A pin high for exactly 24 clocks gives a reset.
- R3: While `core_rst` is high, `port_hi_force` is 1 and `sp_init` reads 8'h07. At all times, including reset, `sbuf_clr` stays 0 so the serial data buffer keeps its value.
- R4: The first edge of `core_rst` clears both power-control bits. `mode_state` then reads 2'b00, and `core_clk_en` and `osc_en` are both 1.
- R5: In run state, a write with `pcon_wdata` = 2'b01 enters idle at the next edge. `mode_state` then reads 2'b01 (bit 0 idle, bit 1 power-down), `core_clk_en` is 0 and `osc_en` stays 1.
- R6: In idle, `irq_pending` high at an edge returns the block to run state at that edge, and `wake_pulse` is high for exactly that one cycle.
- R7: A write with bit 1 set enters power-down: `mode_state` = 2'b10, `core_clk_en` = 0, `osc_en` = 0. Interrupts and further writes do not leave it; only a reset does.
- R8: A write of 2'b11 enters power-down only; idle is not set.
- R9: Writes to the power-control bits while in idle are ignored, and a write of 2'b00 in run state leaves the block in run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_pin | input | 1 | Raw active-high reset pin, asynchronous |
| pcon_wr | input | 1 | Write strobe for the power-control bits |
| pcon_wdata | input | 2 | Bit 0 idle request, bit 1 power-down request |
| irq_pending | input | 1 | Any enabled interrupt pending |
| core_rst | output | 1 | Synchronous core reset, active high |
| core_clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Oscillator enable |
| wake_pulse | output | 1 | One-cycle pulse on idle exit |
| mode_state | output | 2 | Current power-control bits |
| port_hi_force | output | 1 | Drive all port latches high |
| sp_init | output | 8 | Stack-pointer reset value |
| sbuf_clr | output | 1 | Serial buffer clear strobe, held low |

## Verification
The mode properties take for granted that the core is kept in reset until the block's first recognised reset. Before that first reset the power-control bits have no defined history. The bench therefore holds the pin high from time zero for well over the qualification window before it issues any write or interrupt. The synchroniser property assumes nothing about the pin, so the bench changes the pin only on falling clock edges and varies the high-time around the 24-clock limit.

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl #(
  parameter int          MC_CLKS = 12,
  parameter int          QUAL_MC = 2,
  parameter logic [7:0]  SP_RST  = 8'h07
) (
  input  logic       clk,
  input  logic       rst_pin,
  input  logic       pcon_wr,
  input  logic [1:0] pcon_wdata,
  input  logic       irq_pending,
  output logic       core_rst,
  output logic       core_clk_en,
  output logic       osc_en,
  output logic       wake_pulse,
  output logic [1:0] mode_state,
  output logic       port_hi_force,
  output logic [7:0] sp_init,
  output logic       sbuf_clr
);
  localparam int QUAL = MC_CLKS * QUAL_MC;
  localparam int CW   = $clog2(QUAL + 1);

  logic          sync1, sync2;
  logic [CW-1:0] hi_cnt;
  logic          idle_q, pd_q, wake_q;

  always_ff @(posedge clk) begin
    sync1 <= rst_pin;
    sync2 <= sync1;
  end

  always_ff @(posedge clk) begin
    if (!sync2)
      hi_cnt <= '0;
    else if (hi_cnt != CW'(QUAL))
      hi_cnt <= hi_cnt + CW'(1);
  end

  assign core_rst = (hi_cnt == CW'(QUAL));

  always_ff @(posedge clk) begin
    wake_q <= 1'b0;
    if (core_rst) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (pd_q) begin
      pd_q   <= 1'b1;
    end else if (idle_q) begin
      if (irq_pending) begin
        idle_q <= 1'b0;
        wake_q <= 1'b1;
      end
    end else if (pcon_wr) begin
      pd_q   <= pcon_wdata[1];
      idle_q <= pcon_wdata[0] & ~pcon_wdata[1];
    end
  end

  assign core_clk_en   = ~idle_q & ~pd_q;
  assign osc_en        = ~pd_q;
  assign wake_pulse    = wake_q;
  assign mode_state    = {pd_q, idle_q};
  assign port_hi_force = core_rst;
  assign sp_init       = SP_RST;
  assign sbuf_clr      = 1'b0;

  assert_low_sample_blocks_R1: assert property (@(posedge clk)
    !sync2 |=> !core_rst);
  assert_rst_clears_mode_R4: assert property (@(posedge clk)
    core_rst |=> (mode_state == 2'b00));
  assert_idle_wakes_R6: assert property (@(posedge clk) disable iff (core_rst)
    (idle_q && irq_pending) |=> (!idle_q && wake_pulse));
  assert_wake_single_R6: assert property (@(posedge clk)
    wake_pulse |=> !wake_pulse);
  assert_pd_sticky_R7: assert property (@(posedge clk) disable iff (core_rst)
    pd_q |=> pd_q);
  assert_pd_over_idle_R8: assert property (@(posedge clk)
    $onehot0(mode_state));
  assert_idle_ignores_wr_R9: assert property (@(posedge clk) disable iff (core_rst)
    (idle_q && !irq_pending) |=> (idle_q && !pd_q));
endmodule

// File: tb/pwr_rst_ctrl_tb_top.sv
module pwr_rst_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_pin = 1'b1;
  logic       pcon_wr = 1'b0;
  logic [1:0] pcon_wdata = 2'b00;
  logic       irq_pending = 1'b0;
  logic       core_rst, core_clk_en, osc_en, wake_pulse, port_hi_force, sbuf_clr;
  logic [1:0] mode_state;
  logic [7:0] sp_init;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pwr_rst_ctrl dut_i (
    .clk(clk), .rst_pin(rst_pin), .pcon_wr(pcon_wr), .pcon_wdata(pcon_wdata),
    .irq_pending(irq_pending), .core_rst(core_rst), .core_clk_en(core_clk_en),
    .osc_en(osc_en), .wake_pulse(wake_pulse), .mode_state(mode_state),
    .port_hi_force(port_hi_force), .sp_init(sp_init), .sbuf_clr(sbuf_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // {wr, wdata[1:0], irq, exp_mode[1:0], exp_wake}
  localparam logic [6:0] VEC [0:10] = '{
    7'b1_01_0_01_0,  // R5 enter idle
    7'b0_00_0_01_0,  // R5 stays idle
    7'b1_10_0_01_0,  // R9 write ignored in idle
    7'b0_00_1_00_1,  // R6 irq wakes
    7'b0_00_0_00_0,  // R6 pulse one cycle
    7'b1_00_0_00_0,  // R9 write zero
    7'b1_01_1_01_0,  // R5 idle entered despite irq
    7'b0_00_1_00_1,  // R6 wake
    7'b1_11_0_10_0,  // R8 both bits -> pd
    7'b0_00_1_10_0,  // R7 irq ignored
    7'b1_01_1_10_0   // R7 write ignored
  };

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (30) tick();
    chk("R2 reset held", core_rst, 1);
    chk("R3 port force", port_hi_force, 1);
    chk("R3 sp init", sp_init, 8'h07);
    chk("R3 sbuf kept", sbuf_clr, 0);
    chk("R4 mode clear", mode_state, 0);
    chk("R4 clk en", core_clk_en, 1);
    chk("R4 osc en", osc_en, 1);

    @(negedge clk) rst_pin = 1'b0;
    tick(); tick();
    chk("R2 still in reset edge 2", core_rst, 1);
    tick();
    chk("R2 release edge 3", core_rst, 0);
    chk("R3 sbuf kept after", sbuf_clr, 0);

    foreach (VEC[i]) begin
      @(negedge clk);
      pcon_wr = VEC[i][6]; pcon_wdata = VEC[i][5:4]; irq_pending = VEC[i][3];
      tick();
      chk($sformatf("R5-9 vec%0d mode", i), mode_state, VEC[i][2:1]);
      chk($sformatf("R6 vec%0d wake", i), wake_pulse, VEC[i][0]);
      chk($sformatf("R5 vec%0d clk_en", i), core_clk_en, VEC[i][2:1] == 2'b00);
      chk($sformatf("R7 vec%0d osc_en", i), osc_en, !VEC[i][2]);
    end
    @(negedge clk); pcon_wr = 1'b0; irq_pending = 1'b0;
    repeat (5) tick();
    chk("R7 pd persists", mode_state, 2);

    // R1 glitch of 23 clocks
    @(negedge clk) rst_pin = 1'b1;
    repeat (23) @(negedge clk);
    rst_pin = 1'b0;
    n = 0;
    for (int k = 0; k < 30; k++) begin tick(); if (core_rst) n++; end
    chk("R1 23-clock pulse ignored", n, 0);
    chk("R1 pd kept after glitch", mode_state, 2);

    // R1 broken pulse 20 high, 1 low, 20 high
    @(negedge clk) rst_pin = 1'b1;
    repeat (20) @(negedge clk);
    rst_pin = 1'b0;
    @(negedge clk) rst_pin = 1'b1;
    repeat (20) @(negedge clk);
    rst_pin = 1'b0;
    n = 0;
    for (int k = 0; k < 30; k++) begin tick(); if (core_rst) n++; end
    chk("R1 broken pulse ignored", n, 0);

    // R2 exactly 24 clocks qualifies, clears pd (R7, R4)
    @(negedge clk) rst_pin = 1'b1;
    repeat (24) @(negedge clk);
    rst_pin = 1'b0;
    n = 0;
    for (int k = 0; k < 30; k++) begin tick(); if (core_rst) n++; end
    chk("R2 24-clock pulse resets", n > 0, 1);
    chk("R7 reset ends pd", mode_state, 0);
    chk("R4 osc back on", osc_en, 1);

    // R2 latency
    @(negedge clk) rst_pin = 1'b1;
    n = 0;
    for (int k = 1; k <= 40; k++) begin tick(); if (core_rst) begin n = k; break; end end
    chk("R2 assert latency", n, 26);
    chk("R3 port force in reset", port_hi_force, 1);
    @(negedge clk) rst_pin = 1'b0;
    repeat (4) tick();
    chk("R2 released", core_rst, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule